// File: doc/BRIEF.md
# Prescaled Compare Match Timer

This block is a 16-bit up-counter driven by a prescaled enable from the peripheral clock. The counter advances on a single-cycle tick from a free-running prescaler, and a two-bit select field picks one of four division ratios. Software programs a compare value. The counter steps through the values below it, stays on the compare value for one full tick period, and on the next tick it reloads to zero and raises a match flag. So the flag marks the end of the matching count state and not the moment the two values become equal.

Software reaches the block through write strobes for the control/status byte, the counter and the compare register, and through a read strobe on the control/status byte. The flag is cleared by a handshake. Software reads the byte while the flag is 1, then writes 0 to the flag bit. An enable bit routes the flag to an interrupt request. The start input stops the count. While it is low, the counter holds its value and the prescaler returns to zero.

Top module: `cmp_match_timer`

## Requirements
- R1: The select field `csr_wdata[1:0]` chooses the division: 00 divides by 4, 01 by 8, 10 by 16 and 11 by 64. With division D, after `run` rises the first tick falls on the D-th clock edge with `run` high, and one tick follows every D edges after that.
- R2: On a tick, a counter that differs from the compare value increments by one, wrapping from 0xFFFF to 0.
- R3: The counter becoming equal to the compare value does not set the flag. The flag is set only by the next tick while the two are still equal.
- R4: On that match tick the counter reloads to 0, and the flag reads 1 after the same clock edge.
- R5: The flag is cleared only by a control write with bit 7 at 0 that follows a read strobe taken while the flag was 1. Any control write cancels that armed state. A write of 0 without a prior read leaves the flag at 1, and a write of 1 never sets it.
- R6: A match tick on the same edge as a valid clear leaves the flag at 1.
- R7: `irq` is 1 exactly when the flag is 1 and the interrupt-enable bit (control bit 6) is 1.
- R8: While `run` is 0 the counter holds its value and the prescaler returns to zero, so a restart begins a full division period.
- R9: A counter write takes priority over a tick on the same edge. No match event takes place on that edge.
- R10: After reset the counter is 0, the compare register is 0xFFFF, and the control byte, flag and `irq` are 0.
- R11: `csr_rdata` shows the flag in bit 7, the interrupt enable in bit 6 and the select field in bits 1:0, with bits 5:2 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start enable for prescaler and counter |
| csr_re | input | 1 | Read strobe for the control/status byte |
| csr_we | input | 1 | Write strobe for the control/status byte |
| csr_wdata | input | 8 | Control/status write data |
| csr_rdata | output | 8 | Control/status read value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| cnt_q | output | 16 | Current counter value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| cmp_q | output | 16 | Current compare value |
| flag | output | 1 | Compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a match tick that lands on the same edge as a valid flag clear. It needs a flag already set, an armed read and a counter preloaded to the compare value. The write must then be placed on exactly the D-th edge after `run` rises. The bench gets there by holding `run` low while it preloads, so the prescaler phase is known, and then counting edges to line up the clear write. A similar alignment places a counter write on a tick edge, and a start vector above the compare value checks the wrap path.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CSR_W     = 8;
  localparam int SEL_W     = 2;
  localparam int FLAG_BIT  = 7;
  localparam int IE_BIT    = 6;
  localparam int MAX_SHIFT = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIV4  = 2'b00,
    SEL_DIV8  = 2'b01,
    SEL_DIV16 = 2'b10,
    SEL_DIV64 = 2'b11
  } sel_e;

  // log2 of the division ratio picked by the select field
  function automatic int div_shift(input sel_e sel);
    case (sel)
      SEL_DIV4:  return 2;
      SEL_DIV8:  return 3;
      SEL_DIV16: return 4;
      default:   return 6;
    endcase
  endfunction

  // counter next value on a tick: reload on match, else step
  function automatic logic [15:0] next_count(input logic [15:0] cur, input logic hit);
    return hit ? 16'd0 : cur + 16'd1;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  cmt_pkg::sel_e    sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((1 << cmt_pkg::div_shift(sel)) - 1);
    tick = run && ((pre & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (run) pre <= pre + 1'b1;
    else          pre <= '0;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             eq,
  output logic             match_evt
);
  assign eq        = (cnt == cmp);
  assign match_evt = tick && eq && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (tick)  cnt <= CNT_W'(cmt_pkg::next_count(16'(cnt), eq));
  end
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_flag_bit,
  input  logic match_evt,
  output logic flag,
  output logic armed
);
  logic clear_ok;
  assign clear_ok = wr_stb && !wr_flag_bit && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (match_evt)     flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;
      if (wr_stb)                 armed <= 1'b0;
      else if (rd_stb && flag)    armed <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             csr_re,
  input  logic             csr_we,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag,
  output logic             irq
);
  import cmt_pkg::*;
  localparam int PRE_W = MAX_SHIFT;

  sel_e sel;
  logic irq_en;
  logic tick, eq, match_evt, armed;
  logic unused_wbits;
  assign unused_wbits = ^csr_wdata[5:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= SEL_DIV4;
      irq_en <= 1'b0;
      cmp_q  <= '1;
    end else begin
      if (csr_we) begin
        sel    <= sel_e'(csr_wdata[SEL_W-1:0]);
        irq_en <= csr_wdata[IE_BIT];
      end
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_we),
    .wr_data(cnt_wdata), .cmp(cmp_q), .cnt(cnt_q), .eq(eq),
    .match_evt(match_evt)
  );

  cmt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .rd_stb(csr_re), .wr_stb(csr_we),
    .wr_flag_bit(csr_wdata[FLAG_BIT]), .match_evt(match_evt),
    .flag(flag), .armed(armed)
  );

  assign irq       = flag && irq_en;
  assign csr_rdata = {flag, irq_en, 4'b0000, sel};
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             eq,
  input logic             match_evt,
  input logic             armed,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag,
  input logic             irq_en,
  input logic             irq
);
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !tick); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !cnt_we) |=> $stable(cnt_q)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (tick && !cnt_we && !eq) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) match_evt |=> cnt_q == '0); // R4
  AST_FLAG_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n) match_evt |=> flag); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(match_evt)); // R3
  AST_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag) |-> $past(armed)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) cnt_we |=> cnt_q == $past(cnt_wdata)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R7
endmodule

bind cmp_match_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .eq(eq),
  .match_evt(match_evt), .armed(armed), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .flag(flag), .irq_en(irq_en),
  .irq(irq)
);

// File: tb/sim_cmp_match_timer.sv
`timescale 1ns/1ps
module sim_cmp_match_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, csr_re = 1'b0, csr_we = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [15:0] cnt_wdata = '0, cmp_wdata = '0, cnt_q, cmp_q;
  logic flag, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .csr_re(csr_re), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .cmp_q(cmp_q), .flag(flag), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] cmp;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] ecnt;
    logic        eflag;
  } vec_t;

  // sel, compare, start, edges with run high, expected count, expected flag
  localparam vec_t VT [12] = '{
    {2'd0, 16'd5,  16'd0,     8'd16,  16'd4,  1'b0},  // R1 R2
    {2'd0, 16'd5,  16'd0,     8'd20,  16'd5,  1'b0},  // R3 equal, no flag
    {2'd0, 16'd5,  16'd0,     8'd24,  16'd0,  1'b1},  // R4
    {2'd1, 16'd3,  16'd0,     8'd31,  16'd3,  1'b0},  // R1
    {2'd1, 16'd3,  16'd0,     8'd32,  16'd0,  1'b1},  // R1 R4
    {2'd2, 16'd2,  16'd0,     8'd47,  16'd2,  1'b0},  // R1
    {2'd2, 16'd2,  16'd0,     8'd48,  16'd0,  1'b1},  // R1
    {2'd3, 16'd1,  16'd0,     8'd64,  16'd1,  1'b0},  // R1
    {2'd3, 16'd1,  16'd0,     8'd128, 16'd0,  1'b1},  // R1
    {2'd0, 16'd0,  16'd0,     8'd4,   16'd0,  1'b1},  // R4 compare zero
    {2'd0, 16'd10, 16'd12,    8'd12,  16'd15, 1'b0},  // R2 above compare
    {2'd0, 16'd10, 16'hFFFE,  8'd8,   16'd0,  1'b0}   // R2 wrap
  };

  task automatic step(input int k = 1);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d; step(); csr_we = 1'b0;
  endtask

  task automatic csr_read();
    csr_re = 1'b1; step(); csr_re = 1'b0;
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] s);
    cmp_we = 1'b1; cmp_wdata = c; cnt_we = 1'b1; cnt_wdata = s; step();
    cmp_we = 1'b0; cnt_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    check("R10 cnt", cnt_q, 0);
    check("R10 cmp", cmp_q, 16'hFFFF);
    check("R10 csr", csr_rdata, 0);
    check("R10 irq", irq, 0);

    for (int i = 0; i < 12; i++) begin
      run = 1'b0; step();
      csr_read();
      csr_write({6'b0, VT[i].sel});
      load(VT[i].cmp, VT[i].start);
      run = 1'b1;
      step(int'(VT[i].n));
      run = 1'b0;
      check("R1/R2/R3/R4 vec cnt", cnt_q, VT[i].ecnt);
      check("R3/R4 vec flag", flag, VT[i].eflag);
    end

    // obtain a flag, then clear-handshake rules
    csr_write(8'h00);
    load(16'd3, 16'd3);
    run = 1'b1; step(4); run = 1'b0;
    check("R4 reload", cnt_q, 0);
    check("R4 flag", flag, 1);
    csr_write(8'h00);
    check("R5 no read, no clear", flag, 1);
    csr_read();
    csr_write(8'h80);
    check("R5 write one keeps", flag, 1);

    // R6: match and valid clear on the same edge
    csr_read();
    load(16'd3, 16'd3);
    run = 1'b1; step(3);
    csr_we = 1'b1; csr_wdata = 8'h00; step(); csr_we = 1'b0;
    run = 1'b0;
    check("R6 set wins flag", flag, 1);
    check("R6 cnt", cnt_q, 0);
    csr_read();
    csr_write(8'h00);
    check("R5 valid clear", flag, 0);

    // R7 / R11
    load(16'd3, 16'd3);
    run = 1'b1; step(4); run = 1'b0;
    csr_write(8'h40);
    check("R7 irq on", irq, 1);
    check("R11 rdata", csr_rdata, 8'hC0);
    csr_write(8'h02);
    check("R7 irq masked", irq, 0);
    check("R11 rdata sel", csr_rdata, 8'h82);

    // R8: hold and prescaler restart
    csr_write(8'h00);
    load(16'd100, 16'd9);
    step(100);
    check("R8 hold", cnt_q, 9);
    run = 1'b1; step(3); run = 1'b0; step();
    run = 1'b1; step(3);
    check("R8 restart", cnt_q, 9);
    step();
    run = 1'b0;
    check("R8 first tick", cnt_q, 10);

    // R9: counter write on a tick edge
    csr_read();
    csr_write(8'h00);
    load(16'd7, 16'd0);
    run = 1'b1; step(3);
    cnt_we = 1'b1; cnt_wdata = 16'd7; step(); cnt_we = 1'b0;
    check("R9 write wins", cnt_q, 7);
    check("R9 no match", flag, 0);
    step(4);
    run = 1'b0;
    check("R3 next tick cnt", cnt_q, 0);
    check("R3 next tick flag", flag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule